// File: doc/BRIEF.md
# Two-Loop Load/Execute Sequencer

This block is the control state machine of a very small 4-bit processor. It runs in one of two loops. In the load loop, an operator enters each 8-bit instruction by hand as two 4-bit halves through a narrow entry port. The operator presses a strobe once for each half. The sequencer raises the load enables for the low half and then the high half of an external byte buffer. On the next cycle it writes the assembled byte into a ten-entry instruction store at the current program counter. It then advances the counter.

When the tenth instruction has been written, the sequencer clears the counter and enters the execute loop. Each instruction passes through a three-cycle fetch, a decode cycle, an optional operand-fetch cycle and an execute cycle. The class of the decoded instruction chooses the path:

- A reload instruction returns the sequencer to the load loop.
- A halt instruction parks it.
- Out-of-range instruction addresses lead to a sticky instruction-fault state.
- Out-of-range data addresses lead to a sticky data-fault state.

Only a reset leaves the halt and fault states.

The program counter, the buffer, the instruction register, the operand register, the memory address register and the memories all live outside this block. The sequencer sees the counter value and the decoded class, and it drives the strobes.

Top module: `ldexec_seq`

## Requirements
- R1: While `rst_n` is low, `status` reads 0 (loading), `pc_clr` is high and every other strobe is low. After reset is released, the sequencer waits for the first half of an instruction.
- R2: A rising edge of `enter` while the sequencer waits for a low half raises `buf_lo_ld` for exactly one cycle. Holding `enter` high produces no further load.
- R3: The next rising edge of `enter` raises `buf_hi_ld` for one cycle. On the following cycle, `im_we` is high, provided `pc` is at most 9. Together with `im_we`, `pc_inc` is high whenever `pc` is below 9.
- R4: A write at `pc` = 9 raises `pc_clr` instead of `pc_inc`. The next cycle starts execution, with `status` = 1 (running).
- R5: Reaching the write cycle with `pc` above 9 writes nothing and moves to `status` = 3 (instruction fault).
- R6: Fetch raises `im_re`, `ir_ld` and `tp_ld` on three consecutive cycles, in that order. After that comes one decode cycle, where `op_class` is sampled.
- R7: In decode, class 1 (ALU operation with a memory operand) and class 2 (memory access without an operand read) raise `ma_ld`. Class 1 then raises `dm_re` for one cycle before execute. Class 2 goes straight to execute. Class 0 (and the unused values 5 to 7) go straight to execute with no `ma_ld`.
- R8: The execute cycle raises `exec_en` and `pc_inc` together. The next cycle begins a new fetch.
- R9: Class 3 (reload) in decode raises `pc_clr`. The sequencer then returns to waiting for a low half, with `status` = 0.
- R10: Class 4 (halt) in decode leads to `status` = 2. That state keeps all strobes low and ignores `enter` until reset.
- R11: A fetch cycle with `pc` above 9 raises no `im_re` and moves to `status` = 3. This state is sticky until reset.
- R12: An operand-fetch cycle with `dm_addr_ok` low raises no `dm_re` and moves to `status` = 4 (data fault). This state is sticky until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter | input | 1 | Operator strobe; its rising edge accepts one half-instruction |
| op_class | input | 3 | Decoded class of the instruction register |
| pc | input | PC_W | Current program counter value |
| dm_addr_ok | input | 1 | High when the latched data address exists |
| buf_lo_ld | output | 1 | Load the entry port into the buffer's low half |
| buf_hi_ld | output | 1 | Load the entry port into the buffer's high half |
| im_we | output | 1 | Write the buffer into the instruction store at `pc` |
| pc_inc | output | 1 | Advance the program counter |
| pc_clr | output | 1 | Clear the program counter |
| im_re | output | 1 | Read the instruction store at `pc` into the buffer |
| ir_ld | output | 1 | Move the buffer's low half into the instruction register |
| tp_ld | output | 1 | Move the buffer's high half into the operand register |
| ma_ld | output | 1 | Load the memory address register from the operand |
| dm_re | output | 1 | Read the data memory at the latched address |
| exec_en | output | 1 | Execute the current instruction |
| status | output | 3 | 0 loading, 1 running, 2 halted, 3 instruction fault, 4 data fault |

## Verification
The load loop is driven with `enter` held high across cycles, which tells a true edge detector apart from a level detector. It is also tried with writes at an ordinary counter value, at the last slot and at a counter forced past the end. These separate the increment, the switch to execution and the load fault. The execute loop is tried with each instruction class in turn, and the pattern of `ma_ld`, `dm_re` and `exec_en` tells the classes apart. A branch that forces the counter out of range is set against a data address that is reported invalid, which keeps the two fault codes distinct. After a halt and after each fault, `enter` is toggled to show the state holds.

// File: rtl/ldexec_seq.sv
module ldexec_seq #(
  parameter int PC_W     = 4,
  parameter int PROG_LEN = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  logic [2:0]      op_class,
  input  logic [PC_W-1:0] pc,
  input  logic            dm_addr_ok,
  output logic            buf_lo_ld,
  output logic            buf_hi_ld,
  output logic            im_we,
  output logic            pc_inc,
  output logic            pc_clr,
  output logic            im_re,
  output logic            ir_ld,
  output logic            tp_ld,
  output logic            ma_ld,
  output logic            dm_re,
  output logic            exec_en,
  output logic [2:0]      status
);

  localparam logic [PC_W-1:0] LAST = PC_W'(PROG_LEN - 1);

  localparam logic [2:0] C_ALUMEM = 3'd1;
  localparam logic [2:0] C_MEMWR  = 3'd2;
  localparam logic [2:0] C_RELOAD = 3'd3;
  localparam logic [2:0] C_HALT   = 3'd4;

  localparam logic [2:0] ST_LOAD = 3'd0;
  localparam logic [2:0] ST_RUN  = 3'd1;
  localparam logic [2:0] ST_HALT = 3'd2;
  localparam logic [2:0] ST_IFLT = 3'd3;
  localparam logic [2:0] ST_DFLT = 3'd4;

  typedef enum logic [3:0] {
    S_WLO, S_WHI, S_WR, S_F1, S_F2, S_F3, S_DEC, S_OPF, S_EX,
    S_HALT, S_IFLT, S_DFLT
  } state_t;

  state_t st, st_nx;
  logic   enter_q;
  logic   rise, pc_ok, pc_end, needs_ma;

  assign rise     = enter & ~enter_q;
  assign pc_ok    = (pc <= LAST);
  assign pc_end   = (pc == LAST);
  assign needs_ma = (op_class == C_ALUMEM) || (op_class == C_MEMWR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_WLO;
      enter_q <= 1'b0;
    end else begin
      st      <= st_nx;
      enter_q <= enter;
    end
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      S_WLO:  if (rise) st_nx = S_WHI;
      S_WHI:  if (rise) st_nx = S_WR;
      S_WR:   st_nx = !pc_ok ? S_IFLT : (pc_end ? S_F1 : S_WLO);
      S_F1:   st_nx = pc_ok ? S_F2 : S_IFLT;
      S_F2:   st_nx = S_F3;
      S_F3:   st_nx = S_DEC;
      S_DEC: begin
        if (op_class == C_HALT)        st_nx = S_HALT;
        else if (op_class == C_RELOAD) st_nx = S_WLO;
        else if (op_class == C_ALUMEM) st_nx = S_OPF;
        else                           st_nx = S_EX;
      end
      S_OPF:  st_nx = dm_addr_ok ? S_EX : S_DFLT;
      S_EX:   st_nx = S_F1;
      S_HALT, S_IFLT, S_DFLT: st_nx = st;
      default: st_nx = S_IFLT;
    endcase
  end

  assign buf_lo_ld = rst_n && (st == S_WLO) && rise;
  assign buf_hi_ld = rst_n && (st == S_WHI) && rise;
  assign im_we     = rst_n && (st == S_WR) && pc_ok;
  assign pc_inc    = rst_n && (((st == S_WR) && pc_ok && !pc_end) || (st == S_EX));
  assign pc_clr    = !rst_n || ((st == S_WR) && pc_end)
                            || ((st == S_DEC) && (op_class == C_RELOAD));
  assign im_re     = rst_n && (st == S_F1) && pc_ok;
  assign ir_ld     = rst_n && (st == S_F2);
  assign tp_ld     = rst_n && (st == S_F3);
  assign ma_ld     = rst_n && (st == S_DEC) && needs_ma;
  assign dm_re     = rst_n && (st == S_OPF) && dm_addr_ok;
  assign exec_en   = rst_n && (st == S_EX);

  always_comb begin
    unique case (st)
      S_WLO, S_WHI, S_WR: status = ST_LOAD;
      S_HALT:             status = ST_HALT;
      S_IFLT:             status = ST_IFLT;
      S_DFLT:             status = ST_DFLT;
      default:            status = ST_RUN;
    endcase
  end

  // R6
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    im_re |=> ir_ld);
  // R6
  fetch_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |=> tp_ld);
  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_lo_ld, buf_hi_ld, im_we, im_re, ir_ld, tp_ld, ma_ld, dm_re, exec_en}));
  // R3
  write_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    im_we |-> $past(buf_hi_ld));
  // R7
  opnd_after_ma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_re |-> $past(ma_ld));
  // R8
  exec_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> (status == ST_RUN || status == ST_IFLT));
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_HALT |=> status == ST_HALT);
  // R11
  ifault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_IFLT |=> status == ST_IFLT);
  // R12
  dfault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status == ST_DFLT |=> status == ST_DFLT);

endmodule

// File: tb/tb_ldexec_seq.sv
module tb_ldexec_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic [3:0] pc;
  logic dm_addr_ok = 1'b1;
  logic buf_lo_ld, buf_hi_ld, im_we, pc_inc, pc_clr, im_re, ir_ld, tp_ld;
  logic ma_ld, dm_re, exec_en;
  logic [2:0] status;
  logic jump_en = 1'b0;
  logic [3:0] jump_val = 4'd0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (pc_clr)       pc <= 4'd0;
    else if (jump_en) pc <= jump_val;
    else if (pc_inc)  pc <= pc + 4'd1;
  end

  ldexec_seq dut (
    .clk(clk), .rst_n(rst_n), .enter(enter), .op_class(op_class), .pc(pc),
    .dm_addr_ok(dm_addr_ok), .buf_lo_ld(buf_lo_ld), .buf_hi_ld(buf_hi_ld),
    .im_we(im_we), .pc_inc(pc_inc), .pc_clr(pc_clr), .im_re(im_re),
    .ir_ld(ir_ld), .tp_ld(tp_ld), .ma_ld(ma_ld), .dm_re(dm_re),
    .exec_en(exec_en), .status(status)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enter = 1'b0; jump_en = 1'b0; dm_addr_ok = 1'b1; op_class = 3'd0;
    @(negedge clk); #1;
    step();
    chk(status, 0, "R1 status in reset");
    chk(pc_clr, 1, "R1 pc_clr in reset");
    chk({buf_lo_ld, buf_hi_ld, im_we, pc_inc, im_re, ir_ld, tp_ld, ma_ld, dm_re, exec_en}, 0,
        "R1 strobes in reset");
    rst_n = 1'b1;
    step();
  endtask

  task automatic load_one(input bit flt);
    int p;
    enter = 1'b1; #1;
    chk(buf_lo_ld, 1, "R2 low half on rise");
    step();
    chk(buf_lo_ld | buf_hi_ld, 0, "R2 held enter ignored");
    enter = 1'b0;
    step();
    enter = 1'b1; #1;
    chk(buf_hi_ld, 1, "R3 high half on second rise");
    step();
    enter = 1'b0; #1;
    p = pc;
    if (flt) begin
      chk(im_we, 0, "R5 no write past end");
      step();
      chk(status, 3, "R5 load overrun fault");
    end else begin
      chk(im_we, 1, "R3 write after high half");
      chk(pc_inc, (p != 9) ? 1 : 0, "R3 pc_inc on write");
      chk(pc_clr, (p == 9) ? 1 : 0, "R4 pc_clr on last write");
      step();
    end
  endtask

  task automatic load_prog();
    for (int i = 0; i < 10; i++) load_one(1'b0);
    chk(status, 1, "R4 running after ten");
    chk(pc, 0, "R4 pc cleared");
  endtask

  task automatic run_instr(input int cls, input bit dok, input int jmp);
    chk(im_re, 1, "R6 fetch read");
    step();
    chk(ir_ld, 1, "R6 opcode load");
    step();
    chk(tp_ld, 1, "R6 operand load");
    step();
    op_class = 3'(cls); dm_addr_ok = dok; #1;
    chk(ma_ld, (cls == 1 || cls == 2) ? 1 : 0, "R7 ma_ld by class");
    if (cls == 3) begin
      chk(pc_clr, 1, "R9 reload clears pc");
      step();
      chk(status, 0, "R9 back to loading");
      return;
    end
    if (cls == 4) begin
      step();
      chk(status, 2, "R10 halted");
      return;
    end
    step();
    if (cls == 1) begin
      if (!dok) begin
        chk(dm_re, 0, "R12 no read of bad address");
        step();
        chk(status, 4, "R12 data fault");
        return;
      end
      chk(dm_re, 1, "R7 operand read");
      step();
    end
    chk(exec_en, 1, "R8 execute");
    chk(pc_inc, 1, "R8 pc_inc in execute");
    chk(dm_re, 0, "R7 no read in execute");
    if (jmp >= 0) begin jump_en = 1'b1; jump_val = 4'(jmp); end
    step();
    jump_en = 1'b0; #1;
  endtask

  task automatic poke_sticky(input int exp, input string req);
    for (int i = 0; i < 3; i++) begin
      enter = ~enter; #1;
      chk(status, exp, req);
      chk({buf_lo_ld, buf_hi_ld, im_we, im_re, exec_en}, 0, req);
      step();
    end
    enter = 1'b0;
  endtask

  task automatic t_classes();
    do_reset();
    load_prog();
    run_instr(0, 1'b1, -1);
    run_instr(1, 1'b1, -1);
    run_instr(2, 1'b1, -1);
    chk(pc, 3, "R8 pc advanced per instruction");
    run_instr(5, 1'b1, -1);
    run_instr(3, 1'b1, -1);
    load_prog();
    run_instr(4, 1'b1, -1);
    poke_sticky(2, "R10 halt holds");
  endtask

  task automatic t_ifault();
    do_reset();
    load_prog();
    run_instr(0, 1'b1, 12);
    chk(im_re, 0, "R11 no fetch out of range");
    step();
    chk(status, 3, "R11 instruction fault");
    poke_sticky(3, "R11 fault holds");
  endtask

  task automatic t_dfault();
    do_reset();
    load_prog();
    run_instr(1, 1'b0, -1);
    poke_sticky(4, "R12 fault holds");
  endtask

  task automatic t_overrun();
    do_reset();
    for (int i = 0; i < 3; i++) load_one(1'b0);
    chk(status, 0, "R3 still loading");
    jump_en = 1'b1; jump_val = 4'd11;
    step();
    jump_en = 1'b0;
    load_one(1'b1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_classes();
    t_ifault();
    t_dfault();
    t_overrun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule